// File: doc/BRIEF.md
# Host Event Sideband Signaller

This block turns a vector of pending host events into three sideband lines to a host chipset. The lines are an active-low system-management interrupt pulse (`smi_n`), an active-low control-interrupt pulse (`sci_n`) and a level-sensitive active-low wake line (`wake_n`). Each of the three lines has its own mask vector. Firmware presents the current events together with the masks and raises `update` for one cycle. The block then recomputes two status bits (`smi_stat`, `sci_stat`), which a host-side status register can read, and decides which pulses to send.

A pulse holds the line high for one phase, drives it low for one phase, and then releases it high. A phase lasts `PULSE_US` microseconds. The microsecond tick comes from a divider of `CLK_DIV` clock cycles. With the default of 65 µs, the low time satisfies both a host that samples at 32.768 kHz and one that samples at bus speed.

The two pulse lines share one sequencer. Only one line is ever mid-pulse, and the management interrupt always goes first. One-cycle manual strobes can request either pulse directly.

Top module: `host_evt_signaller`

## Requirements
- R1: After reset, `smi_n`, `sci_n` and `wake_n` are 1, and `smi_stat` and `sci_stat` are 0.
- R2: A pulse keeps its line high for PH = `PULSE_US`*`CLK_DIV` cycles after the sequencer starts it, then low for exactly PH cycles, then high again. A start happens one cycle after the request is latched, if the sequencer is idle.
- R3: An accepted update requests an SMI pulse only if `events & smi_mask` is non-zero and `smi_stat` was 0 before the update. Further updates while `smi_stat` is 1 send no further pulse.
- R4: Every accepted update with `events & sci_mask` non-zero requests an SCI pulse, whatever the value of `sci_stat`.
- R5: On each accepted update, `smi_stat` becomes the OR-reduction of `events & smi_mask` and `sci_stat` becomes the OR-reduction of `events & sci_mask`. Both are visible the cycle after the strobe.
- R6: On each accepted update, `wake_n` becomes 0 if `events & wake_mask` is non-zero with bit `PWR_BIT` removed, and 1 otherwise. A power-button bit alone leaves `wake_n` at 1.
- R7: When SMI and SCI requests are both pending at the same time, the SMI pulse completes before the SCI pulse starts.
- R8: A request for a line that arrives while that line's pulse is in progress is latched. Exactly one extra pulse follows, however many requests arrived during the pulse.
- R9: While `init_done` is 0, `update` has no effect on the status bits, on `wake_n` or on the pulse lines.
- R10: `smi_trig` and `sci_trig` each request one pulse on their line, regardless of `init_done` and of the status bits.
- R11: `smi_n` and `sci_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | Enables acceptance of `update` |
| update | input | 1 | One-cycle strobe to re-evaluate the events |
| events | input | EVW | Pending host event vector |
| smi_mask | input | EVW | Events that count toward SMI |
| sci_mask | input | EVW | Events that count toward SCI |
| wake_mask | input | EVW | Events that count toward wake |
| smi_trig | input | 1 | Manual SMI pulse request |
| sci_trig | input | 1 | Manual SCI pulse request |
| smi_n | output | 1 | Active-low SMI pulse line |
| sci_n | output | 1 | Active-low SCI pulse line |
| wake_n | output | 1 | Active-low wake level |
| smi_stat | output | 1 | Masked SMI events present |
| sci_stat | output | 1 | Masked SCI events present |

## Verification
The bench repeats an update while the SMI set is already non-empty. A design that pulsed on the level instead of on the empty-to-non-empty transition would send a second SMI pulse there. It repeats an SCI update after `sci_stat` is already set, which catches a design that edge-gated SCI the same way as SMI. It also fires several requests inside one pulse: dropping the latched request loses a pulse, and counting requests gives too many. Finally, it requests both lines at once, sets the power-button bit alone, and strobes while `init_done` is low. A wrong priority, a wake line that ignored the exclusion, or a missing enable each shows up as a mismatch against the cycle model.

// File: rtl/host_evt_signaller.sv
module host_evt_signaller #(
  parameter int EVW      = 32,
  parameter int CLK_DIV  = 100,
  parameter int PULSE_US = 65,
  parameter int PWR_BIT  = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_done,
  input  logic           update,
  input  logic [EVW-1:0] events,
  input  logic [EVW-1:0] smi_mask,
  input  logic [EVW-1:0] sci_mask,
  input  logic [EVW-1:0] wake_mask,
  input  logic           smi_trig,
  input  logic           sci_trig,
  output logic           smi_n,
  output logic           sci_n,
  output logic           wake_n,
  output logic           smi_stat,
  output logic           sci_stat
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int UW = (PULSE_US > 1) ? $clog2(PULSE_US) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [UW-1:0] US_LAST  = UW'(PULSE_US - 1);
  localparam logic [EVW-1:0] PWR_CLR = ~({{(EVW-1){1'b0}}, 1'b1} << PWR_BIT);

  typedef enum logic [1:0] {IDLE, HI, LO} phase_t;

  phase_t        st;
  logic          sel_sci;
  logic [DW-1:0] div_cnt;
  logic [UW-1:0] us_cnt;
  logic          smi_pend, sci_pend;

  logic accept, smi_any, sci_any, wake_any;
  logic smi_req, sci_req, start_smi, start_sci, tick, phase_end;

  assign accept    = update & init_done;
  assign smi_any   = |(events & smi_mask);
  assign sci_any   = |(events & sci_mask);
  assign wake_any  = |(events & wake_mask & PWR_CLR);
  assign smi_req   = (accept & smi_any & ~smi_stat) | smi_trig;
  assign sci_req   = (accept & sci_any) | sci_trig;
  assign start_smi = (st == IDLE) & smi_pend;
  assign start_sci = (st == IDLE) & ~smi_pend & sci_pend;
  assign tick      = (div_cnt == DIV_LAST);
  assign phase_end = (st != IDLE) & tick & (us_cnt == US_LAST);

  assign smi_n = ~((st == LO) & ~sel_sci);
  assign sci_n = ~((st == LO) & sel_sci);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_stat <= 1'b0;
      sci_stat <= 1'b0;
      wake_n   <= 1'b1;
    end else if (accept) begin
      smi_stat <= smi_any;
      sci_stat <= sci_any;
      wake_n   <= ~wake_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_pend <= 1'b0;
      sci_pend <= 1'b0;
    end else begin
      smi_pend <= (smi_pend & ~start_smi) | smi_req;
      sci_pend <= (sci_pend & ~start_sci) | sci_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      sel_sci <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start_smi | start_sci) begin
                st      <= HI;
                sel_sci <= start_sci;
              end
        HI:   if (phase_end) st <= LO;
        LO:   if (phase_end) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      us_cnt  <= '0;
    end else if (st == IDLE) begin
      div_cnt <= '0;
      us_cnt  <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      us_cnt  <= (us_cnt == US_LAST) ? '0 : us_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // R3
  smi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && smi_any && !smi_stat) |=> smi_pend);

  // R5
  stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (smi_stat == $past(smi_any)) && (sci_stat == $past(sci_any)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(smi_stat) && $stable(sci_stat) && $stable(wake_n));

  // R2
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(smi_n) || $rose(sci_n)) |-> ($past(us_cnt) == US_LAST) && ($past(div_cnt) == DIV_LAST));

  // R7
  smi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && smi_pend && sci_pend) |=> (st == HI) && !sel_sci && sci_pend);
endmodule

// File: tb/host_evt_signaller_tb.sv
module host_evt_signaller_tb;
  localparam int EVW = 16, CDIV = 2, PUS = 5, PH = CDIV * PUS;

  logic clk = 0, rst_n = 0, init_done = 0, update = 0, smi_trig = 0, sci_trig = 0;
  logic [EVW-1:0] events = '0;
  logic [EVW-1:0] smi_mask = 16'h00F0, sci_mask = 16'h0F00, wake_mask = 16'h0003;
  logic smi_n, sci_n, wake_n, smi_stat, sci_stat;

  host_evt_signaller #(.EVW(EVW), .CLK_DIV(CDIV), .PULSE_US(PUS), .PWR_BIT(0)) u_dut (
    .clk, .rst_n, .init_done, .update, .events, .smi_mask, .sci_mask, .wake_mask,
    .smi_trig, .sci_trig, .smi_n, .sci_n, .wake_n, .smi_stat, .sci_stat);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int smi_falls = 0, sci_falls = 0, smi_low = 0, sci_low = 0;
  int smi_rise_at = 0, sci_fall_at = 0;
  bit p_smi = 1, p_sci = 1;

  int m_st = 0, m_sel = 0, m_cnt = 0;
  bit m_sp = 0, m_cp = 0, m_ss = 0, m_cs = 0, m_wn = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sel = 0; m_cnt = 0; m_sp = 0; m_cp = 0; m_ss = 0; m_cs = 0; m_wn = 1;
    end else begin
      bit acc, sa, ca, wa, sreq, creq;
      acc = update && init_done;
      sa = (events & smi_mask) != 0;
      ca = (events & sci_mask) != 0;
      wa = (events & wake_mask & ~16'h0001) != 0;
      sreq = (acc && sa && !m_ss) || smi_trig;
      creq = (acc && ca) || sci_trig;
      if (m_st == 0) begin
        if (m_sp) begin m_st = 1; m_sel = 0; m_cnt = 0; m_sp = 0; end
        else if (m_cp) begin m_st = 1; m_sel = 1; m_cnt = 0; m_cp = 0; end
      end else begin
        m_cnt++;
        if (m_cnt == PH) begin m_cnt = 0; m_st = (m_st == 1) ? 2 : 0; end
      end
      if (sreq) m_sp = 1;
      if (creq) m_cp = 1;
      if (acc) begin m_ss = sa; m_cs = ca; m_wn = !wa; end
    end
  end

  // per-clock compare and pulse monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(smi_n == !(m_st == 2 && m_sel == 0), "R2 R3 R7 smi_n", smi_n, !(m_st == 2 && m_sel == 0));
      chk(sci_n == !(m_st == 2 && m_sel == 1), "R2 R4 R8 sci_n", sci_n, !(m_st == 2 && m_sel == 1));
      chk(wake_n == m_wn, "R6 wake_n", wake_n, m_wn);
      chk(smi_stat == m_ss && sci_stat == m_cs, "R5 status", {smi_stat, sci_stat}, {m_ss, m_cs});
      chk(smi_n || sci_n, "R11 both low", {smi_n, sci_n}, 3);
      if (p_smi && !smi_n) smi_falls++;
      if (p_sci && !sci_n) begin sci_falls++; sci_fall_at = cyc; end
      if (!smi_n) smi_low++;
      if (!sci_n) sci_low++;
      if (!p_smi && smi_n) begin chk(smi_low == PH, "R2 smi low len", smi_low, PH); smi_low = 0; smi_rise_at = cyc; end
      if (!p_sci && sci_n) begin chk(sci_low == PH, "R2 sci low len", sci_low, PH); sci_low = 0; end
      p_smi = smi_n; p_sci = sci_n;
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_update(input logic [EVW-1:0] ev);
    @(negedge clk); events = ev; update = 1;
    @(negedge clk); update = 0;
  endtask

  initial begin
    wait_n(4);
    rst_n = 1;
    wait_n(1);
    // R1
    chk(smi_n && sci_n && wake_n, "R1 lines high", {smi_n, sci_n, wake_n}, 7);
    chk(!smi_stat && !sci_stat, "R1 status clear", {smi_stat, sci_stat}, 0);

    // R9: ignored before init
    do_update(16'hFFFF);
    wait_n(30);
    chk(smi_falls == 0 && sci_falls == 0, "R9 no pulse", smi_falls + sci_falls, 0);
    chk(wake_n && !smi_stat && !sci_stat, "R9 no state", {wake_n, smi_stat, sci_stat}, 4);

    init_done = 1;
    // R3 R5: first SMI event
    do_update(16'h0010);
    chk(smi_stat == 1, "R5 smi_stat set", smi_stat, 1);
    wait_n(30);
    chk(smi_falls == 1, "R3 first smi pulse", smi_falls, 1);
    chk(sci_falls == 0, "R3 no sci", sci_falls, 0);

    // R3: already set, no new pulse
    do_update(16'h0030);
    wait_n(30);
    chk(smi_falls == 1, "R3 no repeat", smi_falls, 1);

    // R5: clear
    do_update(16'h0000);
    chk(smi_stat == 0, "R5 smi_stat clear", smi_stat, 0);

    // R7: both at once
    do_update(16'h0110);
    wait_n(60);
    chk(smi_falls == 2 && sci_falls == 1, "R7 both pulsed", smi_falls * 10 + sci_falls, 21);
    chk(sci_fall_at > smi_rise_at, "R7 smi first", sci_fall_at, smi_rise_at + 1);

    // R4: SCI repeats with status already set
    do_update(16'h0100);
    wait_n(30);
    chk(sci_falls == 2, "R4 sci repeats", sci_falls, 2);

    // R8: requests inside a pulse coalesce into one
    do_update(16'h0100);
    wait_n(5);
    do_update(16'h0100);
    do_update(16'h0100);
    wait_n(60);
    chk(sci_falls == 4, "R8 latched once", sci_falls, 4);

    // R6: wake
    do_update(16'h0001);
    chk(wake_n == 1, "R6 power bit excluded", wake_n, 1);
    do_update(16'h0002);
    chk(wake_n == 0, "R6 wake low", wake_n, 0);
    do_update(16'h0000);
    chk(wake_n == 1, "R6 wake released", wake_n, 1);

    // R10: manual triggers, init off
    init_done = 0;
    @(negedge clk); sci_trig = 1; @(negedge clk); sci_trig = 0;
    wait_n(30);
    chk(sci_falls == 5, "R10 sci trigger", sci_falls, 5);
    @(negedge clk); smi_trig = 1; @(negedge clk); smi_trig = 0;
    wait_n(30);
    chk(smi_falls == 3, "R10 smi trigger", smi_falls, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule